// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the host-facing register bank of a 16550-style serial controller. A host drives a 3-bit offset, separate read and write enables and an 8-bit write bus. The block decodes eight byte offsets into stored settings and pass-through accesses. It holds the interrupt-enable bits, the line-format byte, the modem-control bits, a scratch byte, the FIFO enable and DMA mode bits, and the two divisor bytes.

The meaning of an offset depends on the top bit of the line-format byte, called the bank-select bit here, and on the access direction. When the bit is set, offsets 0 and 1 reach the divisor bytes. When it is clear, a write to offset 0 goes to the transmit path as a strobe with its data, and a read of offset 0 takes the receive byte and strobes the receive path. Offset 2 is FIFO control on a write and interrupt identification on a read. Line status and modem status come from outside the block and are read-only.

Read data is combinational from the stored state, so it is valid in the same cycle as the read enable. Writes take effect at the clock edge. The shift logic reads the divisor, word length, stop length, parity field, break bit and modem-control bits directly from the outputs.

Top module: `uart_regbank`

## Requirements
- R1: After reset, the interrupt enables, the line-format byte, the modem-control bits, the scratch byte, the divisor, fifoEnable and dmaMode are all 0, and reads of offsets 1, 3, 4 and 7 return 0x00.
- R2: With the bank-select bit (line-format bit 7) set, offset 0 writes and reads the divisor low byte, and offset 1 writes and reads the divisor high byte. `divisor` is {high, low}. Such a write raises no txWrStrobe.
- R3: With the bank-select bit clear, a write to offset 0 raises txWrStrobe in the same cycle with txWrData equal to wrData, and it leaves the divisor unchanged. A read of offset 0 returns rxData and raises rxRdStrobe in the same cycle. Neither strobe is raised without its enable.
- R4: With the bank-select bit clear, offset 1 stores wrData[3:0] as the interrupt enables. These appear on intEnable and read back with bits 7:4 as 0.
- R5: A write to offset 2 stores wrData[0] as fifoEnable and wrData[3] as dmaMode. wrData[1] and wrData[2] produce one-cycle pulses on rxFifoClr and txFifoClr in the cycle after the write, and these bits are not stored.
- R6: A read of offset 2 returns iirIn and raises iirRdStrobe in the same cycle. It never returns the FIFO-control settings.
- R7: Offset 3 holds the line-format byte and reads it back whole, whatever the bank-select bit is. Bits 1:0 give dataBits (00=5 up to 11=8 bits), bit 2 gives longStop, bits 5:3 give parityMode (000 none, 001 odd, 011 even), and bit 6 gives breakEn.
- R8: Offset 4 stores wrData[4:0] as the modem-control bits: bit 0 dtr, bit 1 rts, bit 2 out1, bit 3 out2, bit 4 loopback. It reads back with bits 7:5 as 0, whatever the bank-select bit is.
- R9: Reads of offset 5 return lsrIn and reads of offset 6 return msrIn. Writes to offsets 5 and 6 change no stored register.
- R10: Offset 7 is a scratch byte that reads back the last value written.
- R11: When a read and a write hit the bank in the same cycle, the read returns the state from before the write. A change of the bank-select bit applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write enable for this cycle |
| rdEn | input | 1 | Read enable for this cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| txWrStrobe | output | 1 | Transmit byte write to the data path |
| txWrData | output | 8 | Transmit byte |
| rxRdStrobe | output | 1 | Receive byte consumed by the host |
| rxData | input | 8 | Receive byte from the data path |
| iirRdStrobe | output | 1 | Interrupt identification was read |
| iirIn | input | 8 | Interrupt identification value |
| lsrIn | input | 8 | Line status value |
| msrIn | input | 8 | Modem status value |
| divisor | output | 16 | Baud divisor {high, low} |
| dataBits | output | 2 | Word length code |
| longStop | output | 1 | Longer stop period selected |
| parityMode | output | 3 | Parity field |
| breakEn | output | 1 | Force break |
| intEnable | output | 4 | Interrupt enables |
| fifoEnable | output | 1 | FIFOs enabled |
| dmaMode | output | 1 | DMA mode select |
| rxFifoClr | output | 1 | Receive FIFO clear pulse |
| txFifoClr | output | 1 | Transmit FIFO clear pulse |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out1 | output | 1 | Auxiliary output 1 |
| out2 | output | 1 | Auxiliary output 2 |
| loopback | output | 1 | Loopback mode |

## Verification
A read and a write can land in the same cycle, so storage update and read decode can overlap. The bench raises both enables together on the line-format offset with a value that sets the bank-select bit. It expects the read to return the old line-format byte and the next offset-0 read to return the divisor low byte. It then writes and reads offset 0 together with the bank-select bit set, expects the old divisor byte, and reads the new byte on the following access.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int IER_BITS  = 4;
  localparam int MCR_BITS  = 5;
  localparam int DIV_BYTES = 2;
  localparam int DIV_W     = DIV_BYTES * DATA_W;

  localparam logic [ADDR_W-1:0] OFS_BUF   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IER   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_FIFO  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MODEM = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR   = 3'd7;

  typedef enum logic [3:0] {
    SEL_RXBUF, SEL_DIVLO, SEL_DIVHI, SEL_IER, SEL_IIR,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
  } rdSel_e;

  typedef struct packed {
    logic divLo;
    logic divHi;
    logic ier;
    logic fcr;
    logic lcr;
    logic mcr;
    logic scr;
  } wrStrobe_t;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              dlab,
  output wrStrobe_t         wrStrb,
  output rdSel_e            rdSel,
  output logic              txWr,
  output logic              rxRd,
  output logic              iirRd
);
  always_comb begin
    wrStrb = '0;
    txWr   = 1'b0;
    rxRd   = 1'b0;
    iirRd  = 1'b0;
    rdSel  = SEL_SCR;
    case (addr)
      OFS_BUF: begin
        if (dlab) begin
          rdSel        = SEL_DIVLO;
          wrStrb.divLo = wrEn;
        end else begin
          rdSel = SEL_RXBUF;
          txWr  = wrEn;
          rxRd  = rdEn;
        end
      end
      OFS_IER: begin
        if (dlab) begin
          rdSel        = SEL_DIVHI;
          wrStrb.divHi = wrEn;
        end else begin
          rdSel      = SEL_IER;
          wrStrb.ier = wrEn;
        end
      end
      OFS_FIFO: begin
        rdSel      = SEL_IIR;
        wrStrb.fcr = wrEn;
        iirRd      = rdEn;
      end
      OFS_LINE: begin
        rdSel      = SEL_LCR;
        wrStrb.lcr = wrEn;
      end
      OFS_MODEM: begin
        rdSel      = SEL_MCR;
        wrStrb.mcr = wrEn;
      end
      OFS_LSTAT: rdSel = SEL_LSR;
      OFS_MSTAT: rdSel = SEL_MSR;
      default: begin
        rdSel      = SEL_SCR;
        wrStrb.scr = wrEn;
      end
    endcase
  end
endmodule

// File: rtl/uart_reg_dp.sv
module uart_reg_dp
  import uart_regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           wrStrb,
  input  rdSel_e              rdSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [DATA_W-1:0]   iirIn,
  input  logic [DATA_W-1:0]   lsrIn,
  input  logic [DATA_W-1:0]   msrIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   lcrQ,
  output logic [IER_BITS-1:0] ierQ,
  output logic [MCR_BITS-1:0] mcrQ,
  output logic [DIV_W-1:0]    divisor,
  output logic                fifoEn,
  output logic                dmaSel,
  output logic                rxClr,
  output logic                txClr
);
  logic [DIV_BYTES-1:0][DATA_W-1:0] divQ;
  logic [DIV_BYTES-1:0]             divWr;
  logic [DATA_W-1:0]                scrQ;

  assign divWr = {wrStrb.divHi, wrStrb.divLo};

  for (genvar g = 0; g < DIV_BYTES; g++) begin : g_divByte
    always_ff @(posedge clk) begin
      if (!rstN)         divQ[g] <= '0;
      else if (divWr[g]) divQ[g] <= wrData;
    end
  end
  assign divisor = divQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ   <= '0;
      lcrQ   <= '0;
      mcrQ   <= '0;
      scrQ   <= '0;
      fifoEn <= 1'b0;
      dmaSel <= 1'b0;
      rxClr  <= 1'b0;
      txClr  <= 1'b0;
    end else begin
      if (wrStrb.ier) ierQ <= wrData[IER_BITS-1:0];
      if (wrStrb.lcr) lcrQ <= wrData;
      if (wrStrb.mcr) mcrQ <= wrData[MCR_BITS-1:0];
      if (wrStrb.scr) scrQ <= wrData;
      if (wrStrb.fcr) begin
        fifoEn <= wrData[0];
        dmaSel <= wrData[3];
      end
      rxClr <= wrStrb.fcr & wrData[1];
      txClr <= wrStrb.fcr & wrData[2];
    end
  end

  always_comb begin
    case (rdSel)
      SEL_RXBUF: rdData = rxData;
      SEL_DIVLO: rdData = divQ[0];
      SEL_DIVHI: rdData = divQ[1];
      SEL_IER:   rdData = {{(DATA_W-IER_BITS){1'b0}}, ierQ};
      SEL_IIR:   rdData = iirIn;
      SEL_LCR:   rdData = lcrQ;
      SEL_MCR:   rdData = {{(DATA_W-MCR_BITS){1'b0}}, mcrQ};
      SEL_LSR:   rdData = lsrIn;
      SEL_MSR:   rdData = msrIn;
      default:   rdData = scrQ;
    endcase
  end

  // R5
  rx_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxClr |-> $past(wrStrb.fcr && wrData[1]));

  // R5
  tx_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txClr |-> $past(wrStrb.fcr && wrData[2]));

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrb.divLo && !wrStrb.divHi) |=> $stable(divisor));

  // R7
  lcr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrb.lcr |=> lcrQ == $past(wrData));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                txWrStrobe,
  output logic [DATA_W-1:0]   txWrData,
  output logic                rxRdStrobe,
  input  logic [DATA_W-1:0]   rxData,
  output logic                iirRdStrobe,
  input  logic [DATA_W-1:0]   iirIn,
  input  logic [DATA_W-1:0]   lsrIn,
  input  logic [DATA_W-1:0]   msrIn,
  output logic [DIV_W-1:0]    divisor,
  output logic [1:0]          dataBits,
  output logic                longStop,
  output logic [2:0]          parityMode,
  output logic                breakEn,
  output logic [IER_BITS-1:0] intEnable,
  output logic                fifoEnable,
  output logic                dmaMode,
  output logic                rxFifoClr,
  output logic                txFifoClr,
  output logic                dtr,
  output logic                rts,
  output logic                out1,
  output logic                out2,
  output logic                loopback
);
  wrStrobe_t         wrStrb;
  rdSel_e            rdSel;
  logic [DATA_W-1:0] lcrQ;
  logic [MCR_BITS-1:0] mcrQ;

  uart_reg_ctrl u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .dlab   (lcrQ[7]),
    .wrStrb (wrStrb),
    .rdSel  (rdSel),
    .txWr   (txWrStrobe),
    .rxRd   (rxRdStrobe),
    .iirRd  (iirRdStrobe)
  );

  uart_reg_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrStrb  (wrStrb),
    .rdSel   (rdSel),
    .wrData  (wrData),
    .rxData  (rxData),
    .iirIn   (iirIn),
    .lsrIn   (lsrIn),
    .msrIn   (msrIn),
    .rdData  (rdData),
    .lcrQ    (lcrQ),
    .ierQ    (intEnable),
    .mcrQ    (mcrQ),
    .divisor (divisor),
    .fifoEn  (fifoEnable),
    .dmaSel  (dmaMode),
    .rxClr   (rxFifoClr),
    .txClr   (txFifoClr)
  );

  assign txWrData   = wrData;
  assign dataBits   = lcrQ[1:0];
  assign longStop   = lcrQ[2];
  assign parityMode = lcrQ[5:3];
  assign breakEn    = lcrQ[6];
  assign dtr        = mcrQ[0];
  assign rts        = mcrQ[1];
  assign out1       = mcrQ[2];
  assign out2       = mcrQ[3];
  assign loopback   = mcrQ[4];

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == OFS_LSTAT || addr == OFS_MSTAT)) |=>
      ($stable(lcrQ) && $stable(mcrQ) && $stable(intEnable) && $stable(divisor)));

  // R3
  rx_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxRdStrobe |-> (rdData == rxData && rdEn));

  // R6
  iir_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    iirRdStrobe |-> (rdData == iirIn && addr == OFS_FIFO));
endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0, rxData = '0, iirIn = '0, lsrIn = '0, msrIn = '0;
  logic [7:0]  rdData, txWrData;
  logic        txWrStrobe, rxRdStrobe, iirRdStrobe;
  logic [15:0] divisor;
  logic [1:0]  dataBits;
  logic        longStop, breakEn, fifoEnable, dmaMode, rxFifoClr, txFifoClr;
  logic [2:0]  parityMode;
  logic [3:0]  intEnable;
  logic        dtr, rts, out1, out2, loopback;

  int nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  uart_regbank u_uart_regbank (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  // One bus cycle. Sampled values: got/txS/rxS/iirS before the edge,
  // clrR/clrT one cycle after the write edge.
  logic [7:0] got;
  logic txS, rxS, iirS, clrR, clrT;
  task automatic access(bit w, bit r, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    #1;
    got = rdData; txS = txWrStrobe; rxS = rxRdStrobe; iirS = iirRdStrobe;
    @(posedge clk);
    #1;
    wrEn = 1'b0; rdEn = 1'b0;
    clrR = rxFifoClr; clrT = txFifoClr;
  endtask

  task automatic t_reset();
    access(0, 1, 3'd1, 8'h00); chk("R1 ier read", got, 8'h00);
    access(0, 1, 3'd3, 8'h00); chk("R1 lcr read", got, 8'h00);
    access(0, 1, 3'd4, 8'h00); chk("R1 mcr read", got, 8'h00);
    access(0, 1, 3'd7, 8'h00); chk("R1 scratch read", got, 8'h00);
    chk("R1 divisor", divisor, 16'h0);
    chk("R1 fifo/dma", {fifoEnable, dmaMode}, 0);
  endtask

  task automatic t_divisor();
    access(1, 0, 3'd3, 8'h80);
    access(1, 0, 3'd0, 8'h01);
    chk("R2 no tx strobe in bank", txS, 0);
    access(1, 0, 3'd1, 8'h00);
    chk("R2 divisor 1", divisor, 16'h0001);
    access(1, 0, 3'd0, 8'h0C);
    access(1, 0, 3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h120C);
    rxData = 8'hEE;
    access(0, 1, 3'd0, 8'h00);
    chk("R2 low readback", got, 8'h0C);
    chk("R2 no rx strobe in bank", rxS, 0);
    access(0, 1, 3'd1, 8'h00); chk("R2 high readback", got, 8'h12);
    access(0, 1, 3'd3, 8'h00); chk("R7 lcr read with bank set", got, 8'h80);
  endtask

  task automatic t_buffer();
    access(1, 0, 3'd3, 8'h03);
    access(1, 0, 3'd0, 8'h5A);
    chk("R3 tx strobe", txS, 1);
    chk("R3 tx data", txWrData, 8'h5A);
    chk("R3 divisor untouched", divisor, 16'h120C);
    rxData = 8'hA5;
    access(0, 1, 3'd0, 8'h00);
    chk("R3 rx data", got, 8'hA5);
    chk("R3 rx strobe", rxS, 1);
    access(0, 0, 3'd0, 8'h00);
    chk("R3 no strobes idle", {txS, rxS}, 0);
  endtask

  task automatic t_ier();
    access(1, 0, 3'd1, 8'hFF);
    chk("R4 intEnable", intEnable, 4'hF);
    access(0, 1, 3'd1, 8'h00); chk("R4 ier read", got, 8'h0F);
    chk("R4 divisor untouched", divisor, 16'h120C);
    access(1, 0, 3'd1, 8'hA5);
    chk("R4 intEnable 5", intEnable, 4'h5);
  endtask

  task automatic t_fifo();
    access(1, 0, 3'd2, 8'h0F);
    chk("R5 both clear pulses", {clrR, clrT}, 2'b11);
    chk("R5 fifo/dma stored", {fifoEnable, dmaMode}, 2'b11);
    iirIn = 8'hC1;
    access(0, 1, 3'd2, 8'h00);
    chk("R5 pulses end", {clrR, clrT}, 2'b00);
    chk("R6 iir read", got, 8'hC1);
    chk("R6 iir strobe", iirS, 1);
    access(1, 0, 3'd2, 8'h02);
    chk("R5 rx clear only", {clrR, clrT}, 2'b10);
    chk("R5 fifo/dma off", {fifoEnable, dmaMode}, 2'b00);
    access(1, 0, 3'd2, 8'h04);
    chk("R5 tx clear only", {clrR, clrT}, 2'b01);
  endtask

  task automatic t_line();
    access(1, 0, 3'd3, 8'h1F);
    chk("R7 decode a", {dataBits, longStop, parityMode, breakEn}, {2'b11, 1'b1, 3'b011, 1'b0});
    access(1, 0, 3'd3, 8'h4A);
    chk("R7 decode b", {dataBits, longStop, parityMode, breakEn}, {2'b10, 1'b0, 3'b001, 1'b1});
    access(0, 1, 3'd3, 8'h00); chk("R7 lcr read", got, 8'h4A);
  endtask

  task automatic t_modem();
    access(1, 0, 3'd4, 8'hFF);
    chk("R8 all modem bits", {loopback, out2, out1, rts, dtr}, 5'h1F);
    access(0, 1, 3'd4, 8'h00); chk("R8 mcr read", got, 8'h1F);
    access(1, 0, 3'd4, 8'h0A);
    chk("R8 rts out2", {loopback, out2, out1, rts, dtr}, 5'b01010);
  endtask

  task automatic t_status();
    lsrIn = 8'h61; msrIn = 8'hB0;
    access(0, 1, 3'd5, 8'h00); chk("R9 lsr", got, 8'h61);
    access(0, 1, 3'd6, 8'h00); chk("R9 msr", got, 8'hB0);
    access(1, 0, 3'd5, 8'hFF);
    access(1, 0, 3'd6, 8'hFF);
    access(0, 1, 3'd3, 8'h00); chk("R9 lcr kept", got, 8'h4A);
    access(0, 1, 3'd4, 8'h00); chk("R9 mcr kept", got, 8'h0A);
    access(0, 1, 3'd1, 8'h00); chk("R9 ier kept", got, 8'h05);
    access(0, 1, 3'd7, 8'h00); chk("R9 scratch kept", got, 8'h00);
  endtask

  task automatic t_scratch();
    access(1, 0, 3'd7, 8'h3C);
    access(0, 1, 3'd7, 8'h00); chk("R10 scratch", got, 8'h3C);
  endtask

  task automatic t_overlap();
    access(1, 1, 3'd3, 8'h83);
    chk("R11 read sees old lcr", got, 8'h4A);
    access(0, 1, 3'd0, 8'h00);
    chk("R11 bank switch next cycle", got, 8'h0C);
    access(1, 1, 3'd0, 8'h77);
    chk("R11 old divisor byte", got, 8'h0C);
    access(0, 1, 3'd0, 8'h00);
    chk("R11 new divisor byte", got, 8'h77);
    chk("R11 divisor", divisor, 16'h1277);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_divisor();
    t_buffer();
    t_ier();
    t_fifo();
    t_line();
    t_modem();
    t_status();
    t_scratch();
    t_overlap();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule